// File: doc/BRIEF.md
# Watchdog Reset Gate with Sticky Cause Flag

This block sits between a watchdog timer and the system reset controller. It decides whether the watchdog's raw reset request may reach the system. Three control bits take part in that decision. The first is a mask bit, and a parameter sets its polarity. The second is an auto-disable bit, which holds the request back while the processor that owns the watchdog is already in reset. The third is a counter-enable bit, which drives the watchdog counter's run enable.

When a request gets through, the block records it in a sticky cause flag. That flag is reset only by power-on reset, so it survives the system reset that the request itself triggers. Software reads the flag after boot to learn whether the last reset came from the watchdog, and clears it by writing a 1 to it.

To arm the path, software does three things: it clears auto-disable, opens the mask and sets counter-enable. To disarm it, software does the reverse. Each control bit, and the flag, lives in its own word of a small register bus. Each bit sits at a bit position given by a parameter. Every other bit of those words reads as 0 and ignores writes.

Top module: `wdt_rst_gate`

## Requirements
- R1: After power-on reset the block is in its blocked state:
  - the mask bit holds its blocking value: 0 when `MASK_INV`=1, and 1 when `MASK_INV`=0;
  - auto-disable reads 1, and counter-enable reads 0;
  - `cnt_en_o` is 0, the cause flag reads 0, and `sys_rst_o` is 0.
- R2: With `MASK_INV`=1, a 1 at bit `MASK_POS` of word 0 lets the request through, and a 0 blocks it.
- R3: With `MASK_INV`=0, a 1 at bit `MASK_POS` of word 0 blocks the request, and a 0 lets it through.
- R4: When auto-disable (word 1, bit `AUTO_POS`) is 1 and `cpu_in_rst_i` is high, the request is blocked. When either of the two is low, the mask alone decides.
- R5: `sys_rst_o` is registered. It rises on the first rising clock edge at which the request and the gates all allow it, and it is low whenever the request was low at the previous edge.
- R6: `cnt_en_o` equals the counter-enable bit, which is word 2, bit `CNT_POS`. That bit reads back at the same position.
- R7: The cause flag (word 3, bit `STAT_POS`) becomes 1 on the same edge that `sys_rst_o` rises. It stays 1 after the request goes away.
- R8: A blocked request never sets the flag. Writing 0 to the flag leaves it unchanged, and writing 1 to bit `STAT_POS` of word 3 clears it.
- R9: If a passed request and a clearing write fall on the same edge, the flag ends up 1.
- R10: In every word, the bits outside the defined position read 0. Writing to them changes neither the word's own bit nor any other register.
- R11: A register write takes effect on the clock edge at which `wr_en_i` is sampled high, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word select: 0 mask, 1 auto-disable, 2 counter-enable, 3 cause flag |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for the word at `addr_i` (combinational) |
| wdt_req_i | input | 1 | Raw reset request from the watchdog |
| cpu_in_rst_i | input | 1 | High while the owning processor is held in reset |
| sys_rst_o | output | 1 | Gated, registered reset request to the system |
| cnt_en_o | output | 1 | Run enable for the watchdog counter |

## Verification
The bench builds two instances, one of each mask polarity, and feeds both the same request pulses. One mask value therefore has to pass the request on one instance and block it on the other, which shows that the polarity parameter really inverts the sense.

Three patterns are driven in turn:
- The request is held while `cpu_in_rst_i` and auto-disable are toggled. This separates blocking by the mask from blocking by processor reset.
- Cause-flag sequences combine passed and blocked pulses with writes of 0, writes to the other bits, and writes of 1. This tells "sticky" apart from "set by any request" and from "cleared by any write".
- A pass coincides with a clearing write on the same edge. This fixes the set-over-clear priority.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] A_AUTO = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  // Value of the mask bit that keeps the path closed.
  function automatic logic mask_closed_value(input logic inv);
    return ~inv;
  endfunction

  // Auto-disable blocks only while the owning processor is in reset.
  function automatic logic auto_blocks(input logic autodis, input logic cpu_rst);
    return autodis & cpu_rst;
  endfunction

  // The request passes when the mask is open and auto-disable does not block it.
  function automatic logic gate_pass(input logic req, input logic open,
                                     input logic blocked);
    return req & open & ~blocked;
  endfunction
endpackage

// File: rtl/wrg_regs.sv
module wrg_regs #(
  parameter int unsigned DW       = 32,
  parameter int unsigned MASK_POS = 2,
  parameter int unsigned AUTO_POS = 2,
  parameter int unsigned CNT_POS  = 7,
  parameter int unsigned STAT_POS = 24,
  parameter bit          MASK_INV = 1'b1
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       wr_en_i,
  input  logic [wrg_pkg::ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic                       stat_q_i,
  output logic [DW-1:0]              rdata_o,
  output logic                       mask_q_o,
  output logic                       auto_q_o,
  output logic                       cnt_q_o
);
  import wrg_pkg::*;

  logic wr_mask, wr_auto, wr_cnt;
  assign wr_mask = wr_en_i && (addr_i == A_MASK);
  assign wr_auto = wr_en_i && (addr_i == A_AUTO);
  assign wr_cnt  = wr_en_i && (addr_i == A_CNT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mask_q_o <= mask_closed_value(MASK_INV);
      auto_q_o <= 1'b1;
      cnt_q_o  <= 1'b0;
    end else begin
      if (wr_mask) mask_q_o <= wdata_i[MASK_POS];
      if (wr_auto) auto_q_o <= wdata_i[AUTO_POS];
      if (wr_cnt)  cnt_q_o  <= wdata_i[CNT_POS];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MASK:  rdata_o[MASK_POS] = mask_q_o;
      A_AUTO:  rdata_o[AUTO_POS] = auto_q_o;
      A_CNT:   rdata_o[CNT_POS]  = cnt_q_o;
      default: rdata_o[STAT_POS] = stat_q_i;
    endcase
  end

  // R6
  p_cnt_follows_r6: assert property (@(posedge clk) disable iff (!por_n)
    wr_cnt |=> (cnt_q_o == $past(wdata_i[CNT_POS])));

  // R11
  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
    !wr_mask |=> $stable(mask_q_o));
endmodule

// File: rtl/wrg_gate.sv
module wrg_gate #(
  parameter bit MASK_INV = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_i,
  input  logic cpu_rst_i,
  input  logic mask_q_i,
  input  logic auto_q_i,
  output logic fire_o,
  output logic sys_rst_o
);
  import wrg_pkg::*;

  logic mask_open;
  logic auto_block;

  generate
    if (MASK_INV) begin : g_open_high
      assign mask_open = mask_q_i;
    end else begin : g_open_low
      assign mask_open = ~mask_q_i;
    end
  endgenerate

  assign auto_block = auto_blocks(auto_q_i, cpu_rst_i);
  assign fire_o     = gate_pass(req_i, mask_open, auto_block);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sys_rst_o <= 1'b0;
    else        sys_rst_o <= fire_o;
  end

  // R4
  p_auto_block_r4: assert property (@(posedge clk) disable iff (!por_n)
    (auto_q_i && cpu_rst_i) |=> !sys_rst_o);

  // R5
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
    !req_i |=> !sys_rst_o);

  // R2 and R3
  p_mask_pass_r2: assert property (@(posedge clk) disable iff (!por_n)
    (req_i && (mask_q_i == MASK_INV) && !auto_block) |=> sys_rst_o);
endmodule

// File: rtl/wrg_status.sv
module wrg_status (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_q_o
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     stat_q_o <= 1'b0;
    else if (set_i) stat_q_o <= 1'b1;
    else if (clr_i) stat_q_o <= 1'b0;
  end

  // R7
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!por_n)
    set_i |=> stat_q_o);

  // R8
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    (stat_q_o && !clr_i) |=> stat_q_o);
endmodule

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate #(
  parameter int unsigned DW       = 32,
  parameter int unsigned MASK_POS = 2,
  parameter int unsigned AUTO_POS = 2,
  parameter int unsigned CNT_POS  = 7,
  parameter int unsigned STAT_POS = 24,
  parameter bit          MASK_INV = 1'b1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          wdt_req_i,
  input  logic          cpu_in_rst_i,
  output logic          sys_rst_o,
  output logic          cnt_en_o
);
  import wrg_pkg::*;

  logic mask_q, auto_q, cnt_q, stat_q;
  logic fire;
  logic stat_clr;

  assign stat_clr = wr_en_i && (addr_i == A_STAT) && wdata_i[STAT_POS];
  assign cnt_en_o = cnt_q;

  wrg_regs #(
    .DW(DW), .MASK_POS(MASK_POS), .AUTO_POS(AUTO_POS),
    .CNT_POS(CNT_POS), .STAT_POS(STAT_POS), .MASK_INV(MASK_INV)
  ) u_regs (
    .clk(clk), .por_n(por_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .stat_q_i(stat_q), .rdata_o(rdata_o),
    .mask_q_o(mask_q), .auto_q_o(auto_q), .cnt_q_o(cnt_q)
  );

  wrg_gate #(.MASK_INV(MASK_INV)) u_gate (
    .clk(clk), .por_n(por_n), .req_i(wdt_req_i), .cpu_rst_i(cpu_in_rst_i),
    .mask_q_i(mask_q), .auto_q_i(auto_q), .fire_o(fire), .sys_rst_o(sys_rst_o)
  );

  wrg_status u_status (
    .clk(clk), .por_n(por_n), .set_i(fire), .clr_i(stat_clr), .stat_q_o(stat_q)
  );

  // R9
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!por_n)
    (fire && stat_clr) |=> stat_q);
endmodule

// File: tb/test_wdt_rst_gate.sv
`timescale 1ns/1ps
module test_wdt_rst_gate;
  localparam int unsigned MP = 2;
  localparam int unsigned AP = 2;
  localparam int unsigned CP = 7;
  localparam int unsigned SP = 24;
  localparam logic [31:0] MBIT = 32'd1 << MP;
  localparam logic [31:0] ABIT = 32'd1 << AP;
  localparam logic [31:0] CBIT = 32'd1 << CP;
  localparam logic [31:0] SBIT = 32'd1 << SP;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic req = 1'b0;
  logic cpu_rst = 1'b0;
  logic [31:0] rd_i, rd_p;
  logic rst_i, rst_p, cnt_i, cnt_p;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdt_rst_gate #(.MASK_POS(MP), .AUTO_POS(AP), .CNT_POS(CP), .STAT_POS(SP),
                 .MASK_INV(1'b1)) i_wdt_rst_gate (
    .clk(clk), .por_n(por_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_i), .wdt_req_i(req), .cpu_in_rst_i(cpu_rst),
    .sys_rst_o(rst_i), .cnt_en_o(cnt_i));

  wdt_rst_gate #(.MASK_POS(MP), .AUTO_POS(AP), .CNT_POS(CP), .STAT_POS(SP),
                 .MASK_INV(1'b0)) i_wdt_rst_gate_pos (
    .clk(clk), .por_n(por_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_p), .wdt_req_i(req), .cpu_in_rst_i(cpu_rst),
    .sys_rst_o(rst_p), .cnt_en_o(cnt_p));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag,
                    input logic [31:0] exp_i, input logic [31:0] exp_p);
    addr = a; #0.5;
    chk({tag, " inv"}, rd_i, exp_i);
    chk({tag, " pos"}, rd_p, exp_p);
  endtask

  // One request pulse; outputs must stay low before the edge (R5).
  task automatic pulse(input string tag, input logic exp_i, input logic exp_p);
    @(negedge clk); req = 1'b1; #0.5;
    chk("R5 pre-edge inv", {31'd0, rst_i}, 32'd0);
    chk("R5 pre-edge pos", {31'd0, rst_p}, 32'd0);
    @(negedge clk);
    chk({tag, " inv"}, {31'd0, rst_i}, {31'd0, exp_i});
    chk({tag, " pos"}, {31'd0, rst_p}, {31'd0, exp_p});
    req = 1'b0;
    @(negedge clk);
    chk("R5 drop inv", {31'd0, rst_i}, 32'd0);
    chk("R5 drop pos", {31'd0, rst_p}, 32'd0);
  endtask

  task automatic t_reset;
    rd(2'd0, "R1 mask", 32'd0, MBIT);
    rd(2'd1, "R1 auto", ABIT, ABIT);
    rd(2'd2, "R1 cnt", 32'd0, 32'd0);
    rd(2'd3, "R1 flag", 32'd0, 32'd0);
    chk("R1 outputs", {28'd0, rst_i, rst_p, cnt_i, cnt_p}, 32'd0);
  endtask

  task automatic t_polarity;
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd0);
    pulse("R2 R3 mask=0", 1'b0, 1'b1);
    wr(2'd0, MBIT);
    pulse("R2 R3 mask=1", 1'b1, 1'b0);
    rd(2'd3, "R7 flag kept", SBIT, SBIT);
  endtask

  task automatic t_flag;
    wr(2'd3, SBIT);
    rd(2'd3, "R8 clear", 32'd0, 32'd0);
    pulse("R7 pass", 1'b1, 1'b0);
    rd(2'd3, "R8 blocked no set", SBIT, 32'd0);
    wr(2'd3, 32'd0);
    rd(2'd3, "R8 write 0", SBIT, 32'd0);
    wr(2'd3, ~SBIT);
    rd(2'd3, "R10 other bits", SBIT, 32'd0);
    wr(2'd3, SBIT);
    rd(2'd3, "R8 write 1", 32'd0, 32'd0);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 2'd3; wdata = SBIT;
    @(negedge clk); we = 1'b0; req = 1'b0;
    chk("R9 pass out", {31'd0, rst_i}, 32'd1);
    rd(2'd3, "R9 set wins", SBIT, 32'd0);
    wr(2'd3, SBIT);
  endtask

  task automatic t_auto;
    wr(2'd1, ABIT);
    cpu_rst = 1'b1;
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    chk("R4 blocked", {31'd0, rst_i}, 32'd0);
    rd(2'd3, "R8 auto-blocked no set", 32'd0, 32'd0);
    cpu_rst = 1'b0;
    @(negedge clk);
    chk("R4 cpu out of reset", {31'd0, rst_i}, 32'd1);
    wr(2'd1, 32'd0);
    cpu_rst = 1'b1;
    @(negedge clk);
    chk("R4 auto clear", {31'd0, rst_i}, 32'd1);
    req = 1'b0; cpu_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_cnt;
    @(negedge clk); we = 1'b1; addr = 2'd2; wdata = CBIT; #0.5;
    chk("R11 before edge", {31'd0, cnt_i}, 32'd0);
    @(negedge clk); we = 1'b0;
    chk("R6 cnt on", {30'd0, cnt_i, cnt_p}, 32'd3);
    rd(2'd2, "R6 readback", CBIT, CBIT);
    wr(2'd2, ~CBIT);
    chk("R6 cnt off", {30'd0, cnt_i, cnt_p}, 32'd0);
    rd(2'd2, "R10 cnt word", 32'd0, 32'd0);
    wr(2'd2, CBIT);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, "R10 mask word", MBIT, MBIT);
    chk("R10 no cross effect", {30'd0, cnt_i, cnt_p}, 32'd3);
  endtask

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_polarity();
    t_flag();
    t_auto();
    t_cnt();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule